// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Four-Word Lines

This block sits between a processor and a slower main memory. It keeps a direct-mapped store of lines, each holding four 32-bit words. A 32-bit byte address is split into a line tag, a line index, a word-in-line selector and a byte position. A read that finds its line present returns the selected word in the same cycle without stalling.

A read that misses stalls the processor. This happens whether the indexed line is empty or holds a different tag. The controller fetches the whole line from a simple handshaked memory read port, one word at a time, overwrites the line, records the new tag and sets the line's valid flag. It then releases the stall with the requested word on the read bus.

Writes go straight through to memory on a separate write port. A write refreshes the cached word only when its line is already present. A write that misses does not bring a line into the cache. The processor must hold its request, address and write data steady while stall is high.

The controller is a four-state machine. IDLE serves read hits. FILL walks the four words of a refill. DONE is the single cycle that returns the refilled word. WRITE waits for memory to accept a store.

The transitions are:
- IDLE to WRITE on any write request.
- IDLE to FILL on a read request that misses.
- FILL to DONE when the last word is accepted.
- DONE to IDLE unconditionally.
- WRITE to IDLE when memory accepts the store.
- IDLE stays in IDLE on a read hit or when there is no request.

Top module: `dmc_cache`

## Requirements
- R1: Address bits [31:16] are the tag, bits [15:4] select one of 4096 lines, bits [3:2] select the word within the line, and bits [1:0] do not affect the read result.
- R2: After reset every line is invalid, so the first read to any line is a miss. While reset is held, stall, mem_rd_req and mem_wr_req are all low.
- R3: A read to a valid line whose stored tag equals the address tag returns the selected word in the same cycle, with stall low and no memory read issued.
- R4: A read miss raises stall in the same cycle as the request, and stall stays high until the refill completes.
- R5: A refill issues exactly four memory reads, at line base +0, +4, +8 and +12 in that order. Each read holds its request and address until mem_rd_ready is seen.
- R6: Stall falls in the cycle after the last refill word is accepted. In that cycle the requested word is on cpu_rdata, and the line hits from then on.
- R7: A miss to an index that holds another tag replaces that line, so a later read with the old tag misses again.
- R8: A write raises mem_wr_req with the word-aligned address and the write data. Stall stays high until the cycle in which mem_wr_ready is seen, and no memory read is issued during a write.
- R9: A write that hits updates the cached word, so a following read hits and returns the written value.
- R10: A write that misses leaves the cache unchanged, so a following read of that address misses and refills from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Word selected from the indexed line |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_rd_req | output | 1 | Memory word read request |
| mem_rd_addr | output | 32 | Word-aligned memory read address |
| mem_rd_data | input | 32 | Memory read data, valid with mem_rd_ready |
| mem_rd_ready | input | 1 | Memory read accepted and data valid |
| mem_wr_req | output | 1 | Memory word write request |
| mem_wr_addr | output | 32 | Word-aligned memory write address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_ready | input | 1 | Memory write accepted |

## Verification
The hardest situations to reach from the ports are the two kinds of line replacement.

The first is a conflict miss, where a valid line with a different tag is overwritten. The stimulus reaches it by reading a second tag at an index the sweep has just filled, then returning to the first tag. It also revisits the top index under a new tag at every memory latency.

The second is a write miss, whose lack of effect can only be seen through a later read. The bench checks that this read stalls for a full refill and returns the value the write left in the memory model.

Each scenario is repeated at memory latencies of zero, one and two wait cycles, so the stall length is checked against a count computed from the latency.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILL  = 2'd1,
        S_DONE  = 2'd2,
        S_WRITE = 2'd3
    } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int TAG_W = 16,
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             inst_en,
    output logic             hit
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (inst_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en) begin
            tag_q[idx] <= tag;
        end
    end

    assign hit = valid_q[idx] && (tag_q[idx] == tag);

    AST_VALID_ONLY_BY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !inst_en |=> (valid_q == $past(valid_q))); // R10

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 12,
    parameter int WOFF_W = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WOFF_W-1:0] wword,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WOFF_W-1:0] roff,
    output logic [DATA_W-1:0] rdata
);
    localparam int LINES  = 1 << IDX_W;
    localparam int WORDS  = 1 << WOFF_W;
    localparam int LINE_W = WORDS * DATA_W;

    logic [LINE_W-1:0] lines_q [LINES];
    logic [LINE_W-1:0] line;
    logic [DATA_W-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            lines_q[idx][wword*DATA_W +: DATA_W] <= wdata;
        end
    end

    assign line = lines_q[idx];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign words[w] = line[w*DATA_W +: DATA_W];
    end

    assign rdata = words[roff];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 16,
    parameter int IDX_W  = 12,
    parameter int WOFF_W = 2,
    parameter int BOFF_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [WOFF_W-1:0] cpu_off,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              hit,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_ready,
    input  logic              mem_wr_ready,
    output logic              stall,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              dwe,
    output logic [WOFF_W-1:0] dword,
    output logic [DATA_W-1:0] dwdata,
    output logic              inst_en
);
    localparam logic [WOFF_W-1:0] LAST_WORD = '1;
    localparam logic [ADDR_W-1:0] WORD_MASK = ~(ADDR_W'((1 << BOFF_W) - 1));

    dmc_state_e        state_q, state_d;
    logic [WOFF_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (cpu_req && cpu_we) begin
                    state_d = S_WRITE;
                end else if (cpu_req && !hit) begin
                    state_d = S_FILL;
                    cnt_d   = '0;
                end
            end
            S_FILL: begin
                if (mem_rd_ready) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_WORD) begin
                        state_d = S_DONE;
                    end
                end
            end
            S_DONE:  state_d = S_IDLE;
            S_WRITE: begin
                if (mem_wr_ready) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign mem_rd_addr = {cpu_tag, cpu_idx, cnt_q, {BOFF_W{1'b0}}};
    assign mem_wr_addr = cpu_addr & WORD_MASK;
    assign mem_wr_data = cpu_wdata;

    always_comb begin
        stall      = 1'b0;
        mem_rd_req = 1'b0;
        mem_wr_req = 1'b0;
        dwe        = 1'b0;
        dword      = cpu_off;
        dwdata     = cpu_wdata;
        inst_en    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                stall = cpu_req && (cpu_we || !hit);
            end
            S_FILL: begin
                stall      = 1'b1;
                mem_rd_req = 1'b1;
                dword      = cnt_q;
                dwdata     = mem_rd_data;
                if (mem_rd_ready) begin
                    dwe     = 1'b1;
                    inst_en = (cnt_q == LAST_WORD);
                end
            end
            S_DONE: begin
                stall = 1'b0;
            end
            S_WRITE: begin
                mem_wr_req = 1'b1;
                stall      = !mem_wr_ready;
                dwe        = mem_wr_ready && hit;
            end
            default: stall = 1'b0;
        endcase
    end

    AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && cpu_req && !cpu_we && hit) |-> (!stall && !mem_rd_req)); // R3

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ready) |=> (mem_rd_req && $stable(mem_rd_addr))); // R5

    AST_FILL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && mem_rd_ready && cnt_q == LAST_WORD) |=> (!stall && hit)); // R6

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)); // R8

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 12,
    parameter int WOFF_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_ready,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready
);
    localparam int BOFF_W = $clog2(DATA_W / 8);
    localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;

    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WOFF_W-1:0] a_off;
    logic              hit;
    logic              inst_en;
    logic              dwe;
    logic [WOFF_W-1:0] dword;
    logic [DATA_W-1:0] dwdata;

    assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx = cpu_addr[BOFF_W+WOFF_W +: IDX_W];
    assign a_off = cpu_addr[BOFF_W +: WOFF_W];

    dmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (a_idx),
        .tag     (a_tag),
        .inst_en (inst_en),
        .hit     (hit)
    );

    dmc_data_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .WOFF_W(WOFF_W)) u_data (
        .clk   (clk),
        .we    (dwe),
        .idx   (a_idx),
        .wword (dword),
        .wdata (dwdata),
        .roff  (a_off),
        .rdata (cpu_rdata)
    );

    dmc_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .IDX_W  (IDX_W),
        .WOFF_W (WOFF_W),
        .BOFF_W (BOFF_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_tag      (a_tag),
        .cpu_idx      (a_idx),
        .cpu_off      (a_off),
        .cpu_wdata    (cpu_wdata),
        .hit          (hit),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_ready (mem_rd_ready),
        .mem_wr_ready (mem_wr_ready),
        .stall        (cpu_stall),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_wr_req   (mem_wr_req),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .dwe          (dwe),
        .dword        (dword),
        .dwdata       (dwdata),
        .inst_en      (inst_en)
    );

endmodule

// File: tb/dmc_cache_tb.sv
module dmc_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_ready = 1'b0;
    logic        mem_wr_req;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_wr_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int wcnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [31:0] rd_log [16];
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    logic [31:0] ovr [logic [31:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmc_cache u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_stall    (cpu_stall),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_ready (mem_rd_ready),
        .mem_wr_req   (mem_wr_req),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_ready (mem_wr_ready)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        if (ovr.exists(a)) return ovr[a];
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] mk(input logic [15:0] t, input logic [11:0] i,
                                       input logic [1:0] w, input logic [1:0] b);
        return {t, i, w, b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: answers at falling edges after lat wait cycles
    initial begin
        forever begin
            @(negedge clk);
            mem_rd_ready = 1'b0;
            mem_wr_ready = 1'b0;
            if (mem_rd_req) begin
                if (wcnt >= lat) begin
                    mem_rd_ready = 1'b1;
                    mem_rd_data  = memval(mem_rd_addr);
                    rd_log[rd_cnt % 16] = mem_rd_addr;
                    rd_cnt++;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end else if (mem_wr_req) begin
                if (wcnt >= lat) begin
                    mem_wr_ready = 1'b1;
                    ovr[mem_wr_addr] = mem_wr_data;
                    last_wr_addr = mem_wr_addr;
                    last_wr_data = mem_wr_data;
                    wr_cnt++;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end else begin
                wcnt = 0;
            end
        end
    end

    task automatic cpu_access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                              output logic [31:0] d, output int st, output int nr);
        int r0;
        r0 = rd_cnt;
        st = 0;
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = a;
        cpu_wdata = wd;
        #1;
        while (cpu_stall) begin
            st++;
            @(negedge clk);
            #1;
        end
        d = cpu_rdata;
        nr = rd_cnt - r0;
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we = 1'b0;
        #1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int st;
        int nr;
        logic [31:0] a;
        logic [31:0] base;
        logic [15:0] tg;
        logic [11:0] ix;
        logic [31:0] v;

        repeat (3) @(negedge clk);
        #1;
        chk("R2 reset stall", {31'b0, cpu_stall}, 32'd0);
        chk("R2 reset rd_req", {31'b0, mem_rd_req}, 32'd0);
        chk("R2 reset wr_req", {31'b0, mem_wr_req}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        for (int L = 0; L < 3; L++) begin
            lat = L;
            for (int i = 0; i < 6; i++) begin
                tg = 16'h1000 + 16'(L * 16 + i);
                ix = (i == 5) ? 12'hFFF : 12'(i + L * 8);
                a = mk(tg, ix, 2'(i % 4), 2'((i * 3) % 4));
                base = mk(tg, ix, 2'd0, 2'd0);

                // R2 R4: compulsory or conflict miss, stall length from latency
                cpu_access(1'b0, a, '0, d, st, nr);
                chk("R4 miss stall cycles", 32'(st), 32'(1 + 4 * (L + 1)));
                chk("R5 refill read count", 32'(nr), 32'd4);
                for (int k = 0; k < 4; k++) begin
                    chk("R5 refill address order", rd_log[(rd_cnt - 4 + k) % 16], base + 32'(4 * k));
                end
                chk("R6 word at release", d, memval(a & ~32'h3));

                // R1 R3: every word and byte position of the line hits
                for (int w = 0; w < 4; w++) begin
                    for (int b = 0; b < 4; b++) begin
                        cpu_access(1'b0, mk(tg, ix, 2'(w), 2'(b)), '0, d, st, nr);
                        chk("R3 hit no stall", 32'(st), 32'd0);
                        chk("R3 hit no mem read", 32'(nr), 32'd0);
                        chk("R1 word select", d, memval(mk(tg, ix, 2'(w), 2'd0)));
                    end
                end

                if (i == 0) begin
                    // R7: conflicting tag on same index evicts the first
                    cpu_access(1'b0, mk(tg ^ 16'h8000, ix, 2'd2, 2'd0), '0, d, st, nr);
                    chk("R7 conflict miss", 32'(nr), 32'd4);
                    chk("R7 conflict data", d, memval(mk(tg ^ 16'h8000, ix, 2'd2, 2'd0)));
                    cpu_access(1'b0, a, '0, d, st, nr);
                    chk("R7 old tag misses again", 32'(st), 32'(1 + 4 * (L + 1)));
                    chk("R7 old tag data", d, memval(a & ~32'h3));
                end

                // R8 R9: write hit, word-aligned store, cached copy refreshed
                v = ~memval(mk(tg, ix, 2'd1, 2'd0)) + 32'(L);
                cpu_access(1'b1, mk(tg, ix, 2'd1, 2'd3), v, d, st, nr);
                chk("R8 write stall cycles", 32'(st), 32'(1 + L));
                chk("R8 no read during write", 32'(nr), 32'd0);
                chk("R8 write address aligned", last_wr_addr, mk(tg, ix, 2'd1, 2'd0));
                chk("R8 write data", last_wr_data, v);
                cpu_access(1'b0, mk(tg, ix, 2'd1, 2'd2), '0, d, st, nr);
                chk("R9 read after write hits", 32'(st), 32'd0);
                chk("R9 updated word", d, v);

                // R10: write miss does not allocate
                cpu_access(1'b1, mk(tg ^ 16'h4000, ix, 2'd3, 2'd0), v ^ 32'hFFFF_0000, d, st, nr);
                chk("R10 write miss stall", 32'(st), 32'(1 + L));
                cpu_access(1'b0, mk(tg ^ 16'h4000, ix, 2'd3, 2'd0), '0, d, st, nr);
                chk("R10 read after write miss misses", 32'(nr), 32'd4);
                chk("R10 refill sees memory value", d, v ^ 32'hFFFF_0000);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule